// File: doc/BRIEF.md
# Configurable Ready/Busy Interrupt Pin

This block drives the single status pin of a flash-style memory device. Out of reset the pin is a level ready/busy indicator. It is low while the write state machine is busy. It is high when that machine is idle or holds a suspended operation. Software can change the pin's behaviour with a two-write command: a setup write of 0xB8, then a confirm write that carries a configuration code. A non-zero code moves the pin into a pulse mode. In pulse mode the pin rests high and drops low for a fixed number of clock cycles each time an enabled kind of operation finishes.

The configuration logic refuses a confirm code it does not know. It also refuses any configuration made while the device is busy or suspended. In either case it raises two sticky status-register error flags and keeps the current mode. Lock-bit operations never produce a pulse. Clearing the error flags and the write state machine itself belong to neighbouring logic.

Top module: `sts_pin_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the pin is in level mode and both error flags are 0.
- R2: In level mode the pin is combinationally `!wsm_busy || wsm_susp`, in the same cycle as those inputs.
- R3: A write of 0xB8 followed by a write of a code from 0x00 to 0x03, with busy and suspended both low at the confirm write, makes that code the mode. Code bit 0 enables erase-completion pulses and code bit 1 enables program-completion pulses.
- R4: In a pulse mode, the pin is high at rest and ignores `wsm_busy`. An enabled completion strobe drives the pin low for exactly PULSE_LEN cycles, starting with the cycle after the strobe edge. A new enabled strobe restarts the pulse.
- R5: In a pulse mode, a completion whose kind is not enabled leaves the pin high. Kind encoding on `done_kind`: 0 = program, 1 = erase, 2 = lock-bit set, 3 = lock-bit clear.
- R6: Lock-bit completions (kinds 2 and 3) never produce a pulse in any mode.
- R7: Confirm code 0x00 returns the pin to level mode.
- R8: A confirm code above 0x03 sets both error flags on the next edge and leaves the mode unchanged.
- R9: A confirm write that arrives while `wsm_busy` or `wsm_susp` is high is dropped without changing the mode. It sets both error flags.
- R10: A command write that is not the confirm of a pending setup, and whose data is not 0xB8, changes neither the mode nor the error flags.
- R11: Error flags stay set until reset. The mode stays as set until another accepted configuration or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command write strobe, one cycle per write |
| cmd_data | input | 8 | Command data byte |
| wsm_busy | input | 1 | Write state machine busy |
| wsm_susp | input | 1 | Write state machine holds a suspended operation |
| done_vld | input | 1 | Operation completion strobe |
| done_kind | input | 2 | Kind of the completed operation (see R5) |
| sts_o | output | 1 | Status pin level |
| sr_bit4_o | output | 1 | Sticky status error flag, bit 4 |
| sr_bit5_o | output | 1 | Sticky status error flag, bit 5 |

## Verification
The bench sweeps every one of the 256 confirm codes from a fresh reset. After each code it fires all four completion kinds and traces the pin for a full pulse window. This separates valid from invalid codes, and it checks that each code bit gates exactly one operation kind and that lock kinds stay silent. The level mode is checked over all busy/suspended combinations. Holding busy high after configuration shows which mode is in force, because only level mode follows busy. Confirms made under busy or suspended, stray writes with no setup, an invalid code on top of a pulse mode, and a back-to-back retrigger each show that the mode is held, the flags are sticky, and the pulse restarts.

// File: rtl/sts_pkg.sv
// Package: shared encodings for the status pin controller.
// Assumes: completion kinds arrive on a 2-bit field.
package sts_pkg;
    typedef enum logic [1:0] {
        KIND_PROG   = 2'd0,
        KIND_ERASE  = 2'd1,
        KIND_LKSET  = 2'd2,
        KIND_LKCLR  = 2'd3
    } done_kind_e;

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_LEVEL = '0;
endpackage

// File: rtl/sts_cfg_seq.sv
// Module: two-write configuration sequencer for the status pin.
// Holds the pin mode and the two sticky error flags. A setup byte arms
// the sequencer; the next write is the confirm and is always consumed.
// Assumes: cmd_we is a single-cycle strobe per write.
module sts_cfg_seq
    import sts_pkg::*;
#(
    parameter logic [7:0] SETUP_CODE = 8'hB8,
    parameter int         MAX_CODE   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_data,
    input  logic              wsm_busy,
    input  logic              wsm_susp,
    output logic [MODE_W-1:0] mode_q,
    output logic              cfg_load,
    output logic              err4_q,
    output logic              err5_q
);
    logic armed_q;
    logic confirm;
    logic bad_code;
    logic blocked;
    logic reject;

    // Decode the confirm write and its acceptance conditions.
    always_comb begin
        confirm  = cmd_we && armed_q;
        bad_code = (cmd_data > 8'(MAX_CODE));
        blocked  = wsm_busy || wsm_susp;
        reject   = confirm && (bad_code || blocked);
        cfg_load = confirm && !bad_code && !blocked;
    end

    // Track whether a setup write is waiting for its confirm.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (cmd_we)
            armed_q <= !armed_q && (cmd_data == SETUP_CODE);
    end

    // Hold the pin mode; only an accepted confirm changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_LEVEL;
        else if (cfg_load)
            mode_q <= cmd_data[MODE_W-1:0];
    end

    // Sticky error flags, raised by a rejected confirm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err4_q <= 1'b0;
            err5_q <= 1'b0;
        end else if (reject) begin
            err4_q <= 1'b1;
            err5_q <= 1'b1;
        end
    end

    // R8
    bad_code_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && armed_q && cmd_data > 8'(MAX_CODE)) |=> (err4_q && err5_q && $stable(mode_q)));
    // R9
    blocked_confirm_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && armed_q && (wsm_busy || wsm_susp)) |=> ($stable(mode_q) && err4_q && err5_q));
    // R10
    stray_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !armed_q && cmd_data != SETUP_CODE) |=> ($stable(mode_q) && $stable(err4_q) && $stable(err5_q)));
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err4_q || err5_q) |=> (err4_q && err5_q));
endmodule

// File: rtl/sts_pulse_timer.sv
// Module: completion pulse timer for the pulse modes.
// Loads PULSE_LEN when an enabled completion arrives and counts down.
// Mode bit 0 gates erase completions, bit 1 gates program completions.
// Assumes: lock-bit completions are never pulse sources.
module sts_pulse_timer
    import sts_pkg::*;
#(
    parameter int PULSE_LEN = 4,
    localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              cfg_load,
    input  logic              done_vld,
    input  logic [1:0]        done_kind,
    output logic              pulse_on
);
    logic [CNT_W-1:0] cnt_q;
    logic             fire;

    // Decide whether this completion is an enabled pulse source.
    always_comb begin
        unique case (done_kind_e'(done_kind))
            KIND_PROG:  fire = done_vld && mode[1];
            KIND_ERASE: fire = done_vld && mode[0];
            default:    fire = 1'b0;
        endcase
    end

    // Pulse length counter; a new configuration clears any pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cfg_load)
            cnt_q <= '0;
        else if (fire)
            cnt_q <= CNT_W'(PULSE_LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign pulse_on = (cnt_q != '0);

    // R6
    lock_never_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && done_kind[1] && cnt_q == '0) |=> (cnt_q == '0));
    // R4
    pulse_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(PULSE_LEN));
    // R4
    pulse_counts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !done_vld && !cfg_load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sts_pin_ctrl.sv
// Module: top of the configurable ready/busy interrupt pin.
// Level mode: pin follows ready-or-suspended. Pulse modes: pin rests
// high and goes low while a completion pulse is running.
// Assumes: synchronous active-low reset, single clock domain.
module sts_pin_ctrl
    import sts_pkg::*;
#(
    parameter int         PULSE_LEN  = 4,
    parameter logic [7:0] SETUP_CODE = 8'hB8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_data,
    input  logic       wsm_busy,
    input  logic       wsm_susp,
    input  logic       done_vld,
    input  logic [1:0] done_kind,
    output logic       sts_o,
    output logic       sr_bit4_o,
    output logic       sr_bit5_o
);
    logic [MODE_W-1:0] mode;
    logic              cfg_load;
    logic              pulse_on;

    sts_cfg_seq #(
        .SETUP_CODE (SETUP_CODE),
        .MAX_CODE   (3)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .wsm_busy (wsm_busy),
        .wsm_susp (wsm_susp),
        .mode_q   (mode),
        .cfg_load (cfg_load),
        .err4_q   (sr_bit4_o),
        .err5_q   (sr_bit5_o)
    );

    sts_pulse_timer #(
        .PULSE_LEN (PULSE_LEN)
    ) tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .cfg_load  (cfg_load),
        .done_vld  (done_vld),
        .done_kind (done_kind),
        .pulse_on  (pulse_on)
    );

    // Select the pin level from the active mode.
    always_comb begin
        if (mode == MODE_LEVEL)
            sts_o = !wsm_busy || wsm_susp;
        else
            sts_o = !pulse_on;
    end

    // R2
    level_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LEVEL && wsm_busy && !wsm_susp) |-> !sts_o);
    // R4
    pulse_rests_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_LEVEL && !pulse_on) |-> sts_o);
endmodule

// File: tb/sts_pin_ctrl_tb.sv
module sts_pin_ctrl_tb_top;
    localparam int PL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       wsm_busy = 1'b0;
    logic       wsm_susp = 1'b0;
    logic       done_vld = 1'b0;
    logic [1:0] done_kind = 2'd0;
    logic       sts_o, sr_bit4_o, sr_bit5_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sts_pin_ctrl #(.PULSE_LEN(PL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .wsm_busy(wsm_busy), .wsm_susp(wsm_susp), .done_vld(done_vld),
        .done_kind(done_kind), .sts_o(sts_o), .sr_bit4_o(sr_bit4_o),
        .sr_bit5_o(sr_bit5_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_we = 1'b0; done_vld = 1'b0;
        wsm_busy = 1'b0; wsm_susp = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        cmd_we = 1'b1; cmd_data = d;
        tick();
        cmd_we = 1'b0;
    endtask

    // Returns the pin level seen with busy forced high: 0 means level mode.
    task automatic probe_mode(input string tag, input logic exp_pulse_mode);
        wsm_busy = 1'b1; #1;
        chk(tag, sts_o, exp_pulse_mode);
        wsm_busy = 1'b0; #1;
    endtask

    // Fire one completion and trace PL+1 cycles of the pin.
    task automatic fire_trace(input string tag, input logic [1:0] kind, input logic en);
        done_vld = 1'b1; done_kind = kind;
        tick();
        done_vld = 1'b0;
        for (int c = 1; c <= PL + 1; c++) begin
            chk(tag, sts_o, !(en && c <= PL));
            if (c <= PL) tick();
        end
    endtask

    initial begin
        // Watchdog
        fork
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual hung expected done");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        // R1 reset state
        do_reset();
        chk("R1 err4", sr_bit4_o, 1'b0);
        chk("R1 err5", sr_bit5_o, 1'b0);
        chk("R1 level", sts_o, 1'b1);

        // R2 level mode over all busy/suspend combinations
        for (int b = 0; b < 4; b++) begin
            wsm_busy = b[0]; wsm_susp = b[1]; #1;
            chk("R2 level pin", sts_o, !b[0] || b[1]);
        end
        wsm_busy = 1'b0; wsm_susp = 1'b0;

        // R3 R5 R6 R8 sweep of every confirm code and every completion kind
        for (int code = 0; code < 256; code++) begin
            logic       valid;
            logic [1:0] m;
            do_reset();
            wr(8'hB8);
            wr(8'(code));
            valid = (code <= 3);
            m = valid ? 2'(code) : 2'd0;
            chk("R8 err4 vs code", sr_bit4_o, !valid);
            chk("R8 err5 vs code", sr_bit5_o, !valid);
            probe_mode("R3 mode after confirm", m != 2'd0);
            for (int k = 0; k < 4; k++) begin
                logic en;
                en = (k == 0 && m[1]) || (k == 1 && m[0]);
                if (k >= 2) fire_trace("R6 lock kind", 2'(k), en);
                else        fire_trace("R4 R5 completion pulse", 2'(k), en);
            end
        end

        // R4 retrigger restarts the pulse
        do_reset();
        wr(8'hB8); wr(8'h03);
        done_vld = 1'b1; done_kind = 2'd0; tick();
        done_vld = 1'b0; tick();
        done_vld = 1'b1; done_kind = 2'd1; tick();
        done_vld = 1'b0;
        for (int c = 1; c <= PL + 1; c++) begin
            chk("R4 retrigger", sts_o, !(c <= PL));
            if (c <= PL) tick();
        end

        // R9 confirm while busy, then while suspended
        for (int s = 0; s < 2; s++) begin
            do_reset();
            wr(8'hB8);
            wsm_busy = (s == 0); wsm_susp = (s == 1);
            wr(8'h01);
            wsm_busy = 1'b0; wsm_susp = 1'b0;
            chk("R9 err4 blocked", sr_bit4_o, 1'b1);
            chk("R9 err5 blocked", sr_bit5_o, 1'b1);
            probe_mode("R9 mode unchanged", 1'b0);
        end

        // R10 writes with no setup are ignored
        do_reset();
        wr(8'h01); wr(8'h02); wr(8'hFF);
        chk("R10 err4", sr_bit4_o, 1'b0);
        chk("R10 err5", sr_bit5_o, 1'b0);
        probe_mode("R10 mode", 1'b0);

        // R11 invalid code keeps pulse mode; R7 code 0 back to level; flags stay
        do_reset();
        wr(8'hB8); wr(8'h02);
        wr(8'hB8); wr(8'h07);
        probe_mode("R11 mode kept", 1'b1);
        fire_trace("R11 pulse after bad code", 2'd0, 1'b1);
        wr(8'hB8); wr(8'h00);
        probe_mode("R7 back to level", 1'b0);
        chk("R11 err4 sticky", sr_bit4_o, 1'b1);
        chk("R11 err5 sticky", sr_bit5_o, 1'b1);
        do_reset();
        chk("R1 err cleared by reset", sr_bit4_o, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule